// File: doc/BRIEF.md
# Modem Line Status and Control Register Pair

This block holds the modem-side register pair of a serial port. It has a status register and a 5-bit control register. The status register's upper nibble holds the sampled levels of four modem input lines: carrier detect, ring, data-set-ready and clear-to-send. Its lower nibble holds a sticky change flag for each line. The control register drives the request-to-send, terminal-ready and two general-purpose outputs. Its top bit selects loopback, where the outputs are turned back internally onto the inputs.

The four external lines pass through a two-flop synchronizer and are compared with the stored levels on every clock. A detected change ORs a flag into the lower nibble. The ring flag is set only when ring falls. A read of the status register returns its contents and clears the flags. The `delta_pending` output stays high while any flag is set, so an interrupt controller can use it directly. Register access is a byte strobe at two offsets. The control register is at offset 4 and the status register at offset 6.

Top module: `mstat_core`

## Requirements
- R1: After reset the status register reads 0xB0 (bit 7 carrier, bit 6 ring, bit 5 data-set-ready, bit 4 clear-to-send, bits 3:0 flags), the control register reads 0x08, `delta_pending` is 0, `out2_o` is 1 and `rts_o`, `dtr_o`, `out1_o` are 0.
- R2: A control write keeps only bits 4:0 (bit 4 loopback, bit 3 out2, bit 2 out1, bit 1 rts, bit 0 dtr); bits 7:5 read back as 0, and with bit 4 clear each output pin equals its bit from the cycle after the write.
- R3: A change on clear-to-send, data-set-ready or carrier-detect in either direction sets flag bit 0, 1 or 3 respectively and updates the level bit. Both are visible on the third clock edge after the input changes (two synchronizer stages plus the register).
- R4: Ring is stored in bit 6; flag bit 2 is set when ring goes from 1 to 0 and never when it goes from 0 to 1.
- R5: A status read returns the current value, and on the same edge clears bits 3:0 without altering bits 7:4.
- R6: Flags are sticky: a line that changes and changes back before a read leaves its flag set.
- R7: `delta_pending` is 1 exactly when any of status bits 3:0 is set.
- R8: With loopback set, a status read returns carrier = out2, ring = out1, data-set-ready = dtr, clear-to-send = rts, and bits 3:0 as 0.
- R9: With loopback set, the four output pins are held at 0, and external line changes neither alter the stored levels nor set flags.
- R10: When a line change reaches the register on the same edge as a status read, the read returns the old value and the new flag is kept.
- R11: Writes to the status offset have no effect on either register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 3 | Register offset (4 control, 6 status) |
| wr_en | input | 1 | Write strobe, one cycle per byte |
| rd_en | input | 1 | Read strobe; a status read clears the flags at the edge |
| wr_data | input | 8 | Write byte |
| rd_data | output | 8 | Value of the addressed register (0 for other offsets) |
| line_cts | input | 1 | Clear-to-send line, active high |
| line_dsr | input | 1 | Data-set-ready line, active high |
| line_dcd | input | 1 | Carrier-detect line, active high |
| line_ri | input | 1 | Ring line, active high |
| rts_o | output | 1 | Request-to-send output |
| dtr_o | output | 1 | Terminal-ready output |
| out1_o | output | 1 | General-purpose output 1 |
| out2_o | output | 1 | General-purpose output 2 |
| delta_pending | output | 1 | Any change flag set |

## Verification
The assertions assume that the line inputs are stable across each clock edge. They also assume that reset is applied with the lines at their idle pattern (carrier, data-set-ready and clear-to-send high, ring low), so that no flag appears spuriously at reset release. The stimulus changes lines only at falling clock edges and starts from that idle pattern. Before each line change it waits for the synchronizer to settle and reads the status register once to clear leftover flags.

// File: rtl/mstat_pkg.sv
package mstat_pkg;

    typedef struct packed {
        logic dcd;
        logic ri;
        logic dsr;
        logic cts;
    } lines_t;

    typedef struct packed {
        logic loop;
        logic out2;
        logic out1;
        logic rts;
        logic dtr;
    } ctrl_t;

    typedef struct packed {
        lines_t     lvl;
        logic [3:0] flg;
    } status_t;

    localparam lines_t LINES_IDLE = '{dcd: 1'b1, ri: 1'b0, dsr: 1'b1, cts: 1'b1};
    localparam ctrl_t  CTRL_INIT  = '{loop: 1'b0, out2: 1'b1, out1: 1'b0, rts: 1'b0, dtr: 1'b0};

    // Change flags from an old and new line sample; ring only on its falling edge.
    function automatic logic [3:0] change_flags(lines_t old_l, lines_t new_l);
        logic [3:0] f;
        f[3] = old_l.dcd ^ new_l.dcd;
        f[2] = old_l.ri & ~new_l.ri;
        f[1] = old_l.dsr ^ new_l.dsr;
        f[0] = old_l.cts ^ new_l.cts;
        return f;
    endfunction

    // Status view seen in loopback: outputs fed back as inputs, flags zero.
    function automatic status_t loop_view(ctrl_t c);
        status_t s;
        s.lvl.dcd = c.out2;
        s.lvl.ri  = c.out1;
        s.lvl.dsr = c.dtr;
        s.lvl.cts = c.rts;
        s.flg     = 4'b0000;
        return s;
    endfunction

endpackage

// File: rtl/mstat_sync.sv
module mstat_sync #(
    parameter int          STAGES  = 2,
    parameter int          WIDTH   = 4,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] stage_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    stage_q[g] <= RST_VAL;
                end else if (g == 0) begin
                    stage_q[g] <= d;
                end else begin
                    stage_q[g] <= stage_q[(g == 0) ? 0 : g-1];
                end
            end
        end
    endgenerate

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/mstat_ctrl.sv
module mstat_ctrl
    import mstat_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr,
    input  ctrl_t wr_val,
    output ctrl_t ctrl_q,
    output logic  rts_o,
    output logic  dtr_o,
    output logic  out1_o,
    output logic  out2_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= CTRL_INIT;
        end else if (wr) begin
            ctrl_q <= wr_val;
        end
    end

    // Pins go quiet while the outputs are turned back internally.
    always_comb begin
        rts_o  = ctrl_q.rts  & ~ctrl_q.loop;
        dtr_o  = ctrl_q.dtr  & ~ctrl_q.loop;
        out1_o = ctrl_q.out1 & ~ctrl_q.loop;
        out2_o = ctrl_q.out2 & ~ctrl_q.loop;
    end
endmodule

// File: rtl/mstat_status.sv
module mstat_status
    import mstat_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    loop_mode,
    input  logic    rd_clr,
    input  lines_t  sync_lines,
    output status_t sts_q
);
    logic [3:0] kept_flg;
    logic [3:0] new_flg;

    always_comb begin
        new_flg  = change_flags(sts_q.lvl, sync_lines);
        kept_flg = rd_clr ? 4'b0000 : sts_q.flg;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sts_q.lvl <= LINES_IDLE;
            sts_q.flg <= 4'b0000;
        end else if (!loop_mode) begin
            sts_q.lvl <= sync_lines;
            sts_q.flg <= kept_flg | new_flg;
        end
    end
endmodule

// File: rtl/mstat_core.sv
module mstat_core
    import mstat_pkg::*;
#(
    parameter int          ADDR_W    = 3,
    parameter int          SYNC_LEN  = 2,
    parameter logic [ADDR_W-1:0] CTRL_OFS = 3'd4,
    parameter logic [ADDR_W-1:0] STAT_OFS = 3'd6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [7:0]        wr_data,
    output logic [7:0]        rd_data,
    input  logic              line_cts,
    input  logic              line_dsr,
    input  logic              line_dcd,
    input  logic              line_ri,
    output logic              rts_o,
    output logic              dtr_o,
    output logic              out1_o,
    output logic              out2_o,
    output logic              delta_pending
);
    localparam int LINE_W = $bits(lines_t);
    localparam int CTRL_W = $bits(ctrl_t);

    lines_t  raw_lines;
    lines_t  sync_lines;
    ctrl_t   ctrl_q;
    status_t sts_q;
    status_t sts_view;
    logic    loop_mode;
    logic    sel_ctrl;
    logic    sel_stat;

    assign raw_lines = '{dcd: line_dcd, ri: line_ri, dsr: line_dsr, cts: line_cts};
    assign sel_ctrl  = (addr == CTRL_OFS);
    assign sel_stat  = (addr == STAT_OFS);
    assign loop_mode = ctrl_q.loop;

    mstat_sync #(
        .STAGES (SYNC_LEN),
        .WIDTH  (LINE_W),
        .RST_VAL(LINES_IDLE)
    ) u_sync (
        .clk(clk),
        .rst(rst),
        .d  (raw_lines),
        .q  (sync_lines)
    );

    mstat_ctrl u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .wr    (wr_en & sel_ctrl),
        .wr_val(ctrl_t'(wr_data[CTRL_W-1:0])),
        .ctrl_q(ctrl_q),
        .rts_o (rts_o),
        .dtr_o (dtr_o),
        .out1_o(out1_o),
        .out2_o(out2_o)
    );

    mstat_status u_status (
        .clk       (clk),
        .rst       (rst),
        .loop_mode (loop_mode),
        .rd_clr    (rd_en & sel_stat),
        .sync_lines(sync_lines),
        .sts_q     (sts_q)
    );

    assign sts_view      = loop_mode ? loop_view(ctrl_q) : sts_q;
    assign delta_pending = |sts_q.flg;

    always_comb begin
        rd_data = 8'h00;
        if (sel_ctrl) begin
            rd_data = {{(8-CTRL_W){1'b0}}, ctrl_q};
        end else if (sel_stat) begin
            rd_data = sts_view;
        end
    end
endmodule

// File: rtl/mstat_chk.sv
module mstat_chk (
    input logic       clk,
    input logic       rst,
    input logic [2:0] addr,
    input logic       wr_en,
    input logic       rd_en,
    input logic [7:0] wr_data,
    input logic [7:0] rd_data,
    input logic       dtr_o,
    input logic       out2_o,
    input logic       delta_pending,
    input logic       loop_mode,
    input logic [3:0] sync_bus,
    input logic [7:0] sts_byte
);
    AST_CTRL_WRITE_PINS: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == 3'd4 && !wr_data[4]) |=> (dtr_o == $past(wr_data[0]) && out2_o == $past(wr_data[3]))); // R2

    AST_LINE_EDGE_FLAG: assert property (@(posedge clk) disable iff (rst)
        (!loop_mode && ({sync_bus[3], sync_bus[1:0]} != {sts_byte[7], sts_byte[5:4]})) |=> delta_pending); // R3

    AST_RING_FALL_FLAG: assert property (@(posedge clk) disable iff (rst)
        (!loop_mode && sts_byte[6] && !sync_bus[2]) |=> delta_pending); // R4

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == 3'd6 && !loop_mode && sync_bus == sts_byte[7:4]) |=> !delta_pending); // R5

    AST_LOOP_READ_NO_FLAGS: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == 3'd6 && loop_mode) |-> (rd_data[3:0] == 4'b0000)); // R8

    AST_LOOP_LEVELS_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (loop_mode && $past(loop_mode)) |-> $stable(sts_byte[7:4])); // R9

    AST_STAT_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == 3'd6 && !rd_en && !loop_mode && sync_bus == sts_byte[7:4]) |=> $stable(sts_byte)); // R11
endmodule

bind mstat_core mstat_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .addr         (addr),
    .wr_en        (wr_en),
    .rd_en        (rd_en),
    .wr_data      (wr_data),
    .rd_data      (rd_data),
    .dtr_o        (dtr_o),
    .out2_o       (out2_o),
    .delta_pending(delta_pending),
    .loop_mode    (loop_mode),
    .sync_bus     (sync_lines),
    .sts_byte     (sts_q)
);

// File: tb/mstat_core_tb.sv
module mstat_core_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] addr = 3'd0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       line_cts = 1'b1, line_dsr = 1'b1, line_dcd = 1'b1, line_ri = 1'b0;
    logic       rts_o, dtr_o, out1_o, out2_o, delta_pending;
    int         n_chk = 0;
    int         n_bad = 0;
    logic [7:0] got;

    always #5 clk = ~clk;

    mstat_core u_dut (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wr_data(wr_data), .rd_data(rd_data),
        .line_cts(line_cts), .line_dsr(line_dsr), .line_dcd(line_dcd), .line_ri(line_ri),
        .rts_o(rts_o), .dtr_o(dtr_o), .out1_o(out1_o), .out2_o(out2_o),
        .delta_pending(delta_pending)
    );

    // Each entry: {lines dcd,ri,dsr,cts [11:8], expected status byte [7:0]}
    localparam int NV = 8;
    localparam logic [11:0] VEC [NV] = '{
        12'hA_A1, 12'hE_E0, 12'hA_A4, 12'h0_0A,
        12'h0_00, 12'hF_FB, 12'h7_78, 12'hB_BC
    };

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic set_lines(logic [3:0] l);
        {line_dcd, line_ri, line_dsr, line_cts} = l;
    endtask

    task automatic do_read(logic [2:0] a, output logic [7:0] v);
        addr = a; rd_en = 1'b1;
        #1 v = rd_data;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic do_write(logic [2:0] a, logic [7:0] d);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        #1_000_000;
        n_bad++; n_chk++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        do_read(3'd6, got); check("R1 status", got, 8'hB0);
        do_read(3'd4, got); check("R1 control", got, 8'h08);
        check("R1 pins", {4'h0, delta_pending, out2_o, out1_o, rts_o}, 8'h04);
        check("R1 dtr", {7'h0, dtr_o}, 8'h00);

        // R3 R4 R5 R7: vector table walk
        for (int i = 0; i < NV; i++) begin
            set_lines(VEC[i][11:8]);
            repeat (4) @(negedge clk);
            check("R7 pending", {7'h0, delta_pending}, {7'h0, |VEC[i][3:0]});
            do_read(3'd6, got);
            check("R3/R4 status", got, VEC[i][7:0]);
            do_read(3'd6, got);
            check("R5 cleared", got, {VEC[i][11:8], 4'h0});
            check("R7 pending low", {7'h0, delta_pending}, 8'h00);
        end

        // R6 sticky flag: cts low then high again
        set_lines(4'hA); repeat (4) @(negedge clk);
        set_lines(4'hB); repeat (4) @(negedge clk);
        do_read(3'd6, got); check("R6 sticky", got, 8'hB1);

        // R10 change meets read on the same edge
        set_lines(4'hA);
        @(posedge clk); @(posedge clk); @(negedge clk);
        do_read(3'd6, got); check("R10 old value", got, 8'hB0);
        do_read(3'd6, got); check("R10 flag kept", got, 8'hA1);
        set_lines(4'hB); repeat (4) @(negedge clk);
        do_read(3'd6, got);

        // R2 control register width and pins
        do_write(3'd4, 8'hE7);
        do_read(3'd4, got); check("R2 readback", got, 8'h07);
        check("R2 pins", {4'h0, dtr_o, rts_o, out1_o, out2_o}, 8'h0E);

        // R11 write to status offset ignored
        do_write(3'd6, 8'hFF);
        do_read(3'd6, got); check("R11 status", got, 8'hB0);
        do_read(3'd4, got); check("R11 control", got, 8'h07);

        // R8 loopback view: loop, out2=1, out1=0, rts=1, dtr=0
        do_write(3'd4, 8'h1A);
        do_read(3'd6, got); check("R8 loop view", got, 8'h90);
        check("R9 pins quiet", {4'h0, dtr_o, rts_o, out1_o, out2_o}, 8'h00);

        // R9 external change while looped back leaves no trace
        set_lines(4'hA); repeat (4) @(negedge clk);
        check("R9 no pending", {7'h0, delta_pending}, 8'h00);
        set_lines(4'hB); repeat (4) @(negedge clk);
        do_write(3'd4, 8'h08);
        repeat (4) @(negedge clk);
        do_read(3'd6, got); check("R9 status after loop", got, 8'hB0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule